// File: doc/BRIEF.md
# Voice envelope ramp and volume scaler

This unit holds the per-voice envelope state of a sample-playback voice: a left volume, a right volume and two filter coefficients, each 16 bits wide and each paired with a signed 8-bit step. A 9-bit envelope counter sets how many update ticks the stepping lasts. On each update strobe with a nonzero counter, every lane moves by its step, saturating at the ends of the 16-bit range, and the counter counts down by one. The two coefficient lanes can be put in a slow mode, in which they move only on one tick out of every eight.

On the same strobe, the unit scales a signed 16-bit sample by the left and by the right volume. Each volume is read as a pseudo-floating-point gain: a 4-bit exponent and an 8-bit mantissa. The left and right products are registered. They read zero while the voice is muted or switched off.

Top module: `voice_env_unit`

## Requirements
- R1: On a clock with `upd` high and `cnt_q` nonzero, `cnt_q` decreases by one and the lanes may step. With `cnt_q` zero, no lane steps and the counter stays at zero. No lane changes on a clock without `upd`, except through a load.
- R2: The lanes are indexed as follows: 0 is left volume, 1 is right volume, 2 is coefficient one and 3 is coefficient two. Lane i sits in `val_q[16*i+15:16*i]`. On a stepping tick, a lane whose step is nonzero adds its step, read as a two's-complement 8-bit value. A lane whose step is zero keeps its value.
- R3: The result of a step is clamped to the range 0 through 0xFFFF. It never wraps.
- R4: Lanes 2 and 3 each hold a slow bit. With the slow bit set, the lane steps only on ticks where the 3-bit tick counter is 0. Lanes 0 and 1 ignore `slow_din` and always step on stepping ticks.
- R5: The tick counter resets to 0. It increments modulo 8 on every `upd`, including ticks where `cnt_q` is zero.
- R6: In a volume word, bits [15:12] are the exponent e and bits [11:4] are the mantissa m. The output on a strobe is sample × (256 + m), arithmetically shifted right by (20 − e). The volume used is the lane value held before that tick's step.
- R7: On a strobe with `mute` high or `voice_on` low, both outputs become zero.
- R8: A `val_ld[i]` or `cnt_ld` load takes priority over a step or decrement in the same clock. A `ramp_ld[i]` load takes effect from the next tick: a step in the same clock uses the previous step value.
- R9: `out_l` and `out_r` update on the clock edge that samples `upd` high, so they are valid in the cycle after the strobe. They hold their value while `upd` is low.
- R10: After reset, all lanes, steps, slow bits, the counter, the tick counter and both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd | input | 1 | Voice update tick strobe |
| cnt_ld | input | 1 | Load envelope counter |
| cnt_din | input | 9 | Envelope counter load value |
| val_ld | input | 4 | Per-lane value load |
| val_din | input | 64 | Lane load values, 16 bits per lane |
| ramp_ld | input | 4 | Per-lane step (and slow bit) load |
| ramp_din | input | 8 | Step load value, signed |
| slow_din | input | 1 | Slow bit load value (lanes 2 and 3 only) |
| sample_in | input | 16 | Signed sample to scale |
| voice_on | input | 1 | Voice active |
| mute | input | 1 | Voice muted |
| val_q | output | 64 | Current lane values |
| cnt_q | output | 9 | Current envelope counter |
| out_l | output | 25 | Signed left product |
| out_r | output | 25 | Signed right product |

## Verification
The hardest case to reach is the phase of a slow coefficient lane. The tick counter cannot be seen at the ports, and it keeps advancing while the envelope is idle. The stimulus therefore issues updates with the counter at zero to shift the phase, then restarts the envelope and confirms that the slow lane moves only on the expected eighth ticks. Saturation is reached by loading values near each end of the range with the largest steps, and by sweeping all sixteen exponents with extreme samples.

// File: rtl/env_pkg.sv
package env_pkg;
  localparam int VAL_W   = 16;
  localparam int RAMP_W  = 8;
  localparam int CNT_W   = 9;
  localparam int TICK_W  = 3;
  localparam int SAMP_W  = 16;
  localparam int EXP_W   = 4;
  localparam int MANT_W  = 8;
  localparam int LANES   = 4;
  localparam int PROD_W  = SAMP_W + MANT_W + 1;
  localparam int SH_BASE = VAL_W + EXP_W;

  // add a signed step to an unsigned value, saturate to the value range
  function automatic logic [VAL_W-1:0] ramp_sat(input logic [VAL_W-1:0] v,
                                                input logic [RAMP_W-1:0] r);
    logic signed [VAL_W+1:0] s;
    s = $signed({2'b00, v}) + $signed({{(VAL_W+2-RAMP_W){r[RAMP_W-1]}}, r});
    if (s < 0) return '0;
    else if (s > $signed({2'b00, {VAL_W{1'b1}}})) return '1;
    else return s[VAL_W-1:0];
  endfunction

  // pseudo-floating-point gain: sample * (1.mant) >>> (SH_BASE - exp)
  function automatic logic signed [PROD_W-1:0] vol_scale(input logic signed [SAMP_W-1:0] smp,
                                                         input logic [VAL_W-1:0] vol);
    logic [EXP_W-1:0]         e;
    logic [MANT_W-1:0]        m;
    logic signed [PROD_W-1:0] p;
    logic [4:0]               sh;
    e  = vol[VAL_W-1 -: EXP_W];
    m  = vol[VAL_W-EXP_W-1 -: MANT_W];
    p  = smp * $signed({2'b01, m});
    sh = 5'(SH_BASE) - {1'b0, e};
    return p >>> sh;
  endfunction
endpackage

// File: rtl/env_tick_ctl.sv
module env_tick_ctl
  import env_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic             cnt_ld,
  input  logic [CNT_W-1:0] cnt_din,
  output logic [CNT_W-1:0] cnt_q,
  output logic             upd_go,
  output logic             tick_zero
);
  logic [TICK_W-1:0] tick_q;

  assign upd_go    = upd && (cnt_q != '0);
  assign tick_zero = (tick_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= '0;
    end else begin
      if (cnt_ld)      cnt_q <= cnt_din;
      else if (upd_go) cnt_q <= cnt_q - 1'b1;
      if (upd)         tick_q <= tick_q + 1'b1;
    end
  end

  assert_cnt_dec_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !cnt_ld && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  assert_cnt_rest_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !cnt_ld && cnt_q == '0) |=> (cnt_q == '0));
  assert_cnt_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ld |=> (cnt_q == $past(cnt_din)));
  assert_tick_adv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (tick_q == $past(tick_q) + 1'b1));
endmodule

// File: rtl/env_ramp_lane.sv
module env_ramp_lane
  import env_pkg::*;
#(
  parameter bit SLOW_OK = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_go,
  input  logic              tick_zero,
  input  logic              val_ld,
  input  logic [VAL_W-1:0]  val_din,
  input  logic              ramp_ld,
  input  logic [RAMP_W-1:0] ramp_din,
  input  logic              slow_din,
  output logic [VAL_W-1:0]  val_q
);
  logic [RAMP_W-1:0] ramp_q;
  logic              slow_q;
  logic              step;

  assign step = upd_go && (ramp_q != '0) && (!slow_q || tick_zero);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q  <= '0;
      ramp_q <= '0;
      slow_q <= 1'b0;
    end else begin
      if (val_ld)    val_q <= val_din;
      else if (step) val_q <= ramp_sat(val_q, ramp_q);
      if (ramp_ld) begin
        ramp_q <= ramp_din;
        slow_q <= slow_din & SLOW_OK;
      end
    end
  end

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_go && !val_ld) |=> $stable(val_q));
  assert_load_prio_R8: assert property (@(posedge clk) disable iff (!rst_n)
    val_ld |=> (val_q == $past(val_din)));
  assert_down_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_go && !val_ld && ramp_q[RAMP_W-1]) |=> (val_q <= $past(val_q)));
  assert_up_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_go && !val_ld && !ramp_q[RAMP_W-1]) |=> (val_q >= $past(val_q)));

  generate
    if (SLOW_OK) begin : g_slow_chk
      assert_slow_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_go && slow_q && !tick_zero && !val_ld) |=> $stable(val_q));
    end
  endgenerate
endmodule

// File: rtl/env_vol_scale.sv
module env_vol_scale
  import env_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     upd,
  input  logic                     en,
  input  logic signed [SAMP_W-1:0] sample_in,
  input  logic [VAL_W-1:0]         vol_l,
  input  logic [VAL_W-1:0]         vol_r,
  output logic [PROD_W-1:0]        out_l,
  output logic [PROD_W-1:0]        out_r
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_l <= '0;
      out_r <= '0;
    end else if (upd) begin
      out_l <= en ? vol_scale(sample_in, vol_l) : '0;
      out_r <= en ? vol_scale(sample_in, vol_r) : '0;
    end
  end

  assert_mute_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !en) |=> (out_l == '0 && out_r == '0));
  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> ($stable(out_l) && $stable(out_r)));
  assert_zero_in_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && sample_in == '0) |=> (out_l == '0 && out_r == '0));
endmodule

// File: rtl/voice_env_unit.sv
module voice_env_unit
  import env_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd,
  input  logic                    cnt_ld,
  input  logic [CNT_W-1:0]        cnt_din,
  input  logic [LANES-1:0]        val_ld,
  input  logic [LANES*VAL_W-1:0]  val_din,
  input  logic [LANES-1:0]        ramp_ld,
  input  logic [RAMP_W-1:0]       ramp_din,
  input  logic                    slow_din,
  input  logic [SAMP_W-1:0]       sample_in,
  input  logic                    voice_on,
  input  logic                    mute,
  output logic [LANES*VAL_W-1:0]  val_q,
  output logic [CNT_W-1:0]        cnt_q,
  output logic [PROD_W-1:0]       out_l,
  output logic [PROD_W-1:0]       out_r
);
  logic upd_go;
  logic tick_zero;

  env_tick_ctl u_tick (
    .clk(clk), .rst_n(rst_n), .upd(upd), .cnt_ld(cnt_ld), .cnt_din(cnt_din),
    .cnt_q(cnt_q), .upd_go(upd_go), .tick_zero(tick_zero)
  );

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      env_ramp_lane #(.SLOW_OK(i >= 2)) u_lane (
        .clk(clk), .rst_n(rst_n), .upd_go(upd_go), .tick_zero(tick_zero),
        .val_ld(val_ld[i]), .val_din(val_din[i*VAL_W +: VAL_W]),
        .ramp_ld(ramp_ld[i]), .ramp_din(ramp_din), .slow_din(slow_din),
        .val_q(val_q[i*VAL_W +: VAL_W])
      );
    end
  endgenerate

  env_vol_scale u_scale (
    .clk(clk), .rst_n(rst_n), .upd(upd), .en(voice_on && !mute),
    .sample_in($signed(sample_in)), .vol_l(val_q[0 +: VAL_W]), .vol_r(val_q[VAL_W +: VAL_W]),
    .out_l(out_l), .out_r(out_r)
  );
endmodule

// File: tb/voice_env_unit_tb.sv
module voice_env_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd = 1'b0;
  logic        cnt_ld = 1'b0;
  logic [8:0]  cnt_din = '0;
  logic [3:0]  val_ld = '0;
  logic [63:0] val_din = '0;
  logic [3:0]  ramp_ld = '0;
  logic [7:0]  ramp_din = '0;
  logic        slow_din = 1'b0;
  logic [15:0] sample_in = '0;
  logic        voice_on = 1'b0;
  logic        mute = 1'b0;
  logic [63:0] val_q;
  logic [8:0]  cnt_q;
  logic [24:0] out_l, out_r;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference state
  int m_val[4];
  int m_ramp[4];
  int m_slow[4];
  int m_cnt, m_tick, m_ol, m_or;
  int seed = 16'h1d35;

  always #5 clk = ~clk;

  voice_env_unit dut_i (
    .clk(clk), .rst_n(rst_n), .upd(upd), .cnt_ld(cnt_ld), .cnt_din(cnt_din),
    .val_ld(val_ld), .val_din(val_din), .ramp_ld(ramp_ld), .ramp_din(ramp_din),
    .slow_din(slow_din), .sample_in(sample_in), .voice_on(voice_on), .mute(mute),
    .val_q(val_q), .cnt_q(cnt_q), .out_l(out_l), .out_r(out_r)
  );

  function automatic int ref_scale(int s, int vol);
    int e, m, prod;
    e = vol / 4096;
    m = (vol / 16) % 256;
    prod = s * (256 + m);
    return prod >>> (20 - e);
  endfunction

  function automatic int ref_step(int v, int r);
    int d, n;
    d = (r >= 128) ? r - 256 : r;
    n = v + d;
    if (n < 0) n = 0;
    if (n > 65535) n = 65535;
    return n;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin m_val[i] = 0; m_ramp[i] = 0; m_slow[i] = 0; end
    m_cnt = 0; m_tick = 0; m_ol = 0; m_or = 0;
  endtask

  task automatic model_update();
    int nv[4];
    bit go;
    int s;
    s = $signed(sample_in);
    go = upd && (m_cnt != 0);
    if (upd) begin
      m_ol = (voice_on && !mute) ? ref_scale(s, m_val[0]) : 0;
      m_or = (voice_on && !mute) ? ref_scale(s, m_val[1]) : 0;
    end
    for (int i = 0; i < 4; i++) begin
      nv[i] = m_val[i];
      if (val_ld[i]) nv[i] = int'(val_din[16*i +: 16]);
      else if (go && m_ramp[i] != 0 && (m_slow[i] == 0 || m_tick == 0))
        nv[i] = ref_step(m_val[i], m_ramp[i]);
    end
    for (int i = 0; i < 4; i++) begin
      m_val[i] = nv[i];
      if (ramp_ld[i]) begin
        m_ramp[i] = int'(ramp_din);
        m_slow[i] = (i >= 2) ? int'(slow_din) : 0;
      end
    end
    if (cnt_ld) m_cnt = int'(cnt_din);
    else if (go) m_cnt = m_cnt - 1;
    if (upd) m_tick = (m_tick + 1) % 8;
  endtask

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    for (int i = 0; i < 4; i++)
      check(tag, $sformatf("lane%0d", i), int'(val_q[16*i +: 16]), m_val[i]);
    check(tag, "cnt", int'(cnt_q), m_cnt);
    check(tag, "out_l", $signed(out_l), m_ol);
    check(tag, "out_r", $signed(out_r), m_or);
  endtask

  // one clock: inputs already set at negedge
  task automatic cyc(string tag);
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare(tag);
    upd = 0; cnt_ld = 0; val_ld = '0; ramp_ld = '0;
  endtask

  task automatic next_sample();
    seed = (seed * 1103 + 12345) % 65536;
    sample_in = 16'(seed);
  endtask

  task automatic ld_val(int i, int v, string tag);
    val_ld[i] = 1'b1; val_din[16*i +: 16] = 16'(v);
    cyc(tag);
  endtask

  task automatic ld_ramp(int i, int r, bit s, string tag);
    ramp_ld[i] = 1'b1; ramp_din = 8'(r); slow_din = s;
    cyc(tag);
  endtask

  task automatic ld_cnt(int c, string tag);
    cnt_ld = 1'b1; cnt_din = 9'(c);
    cyc(tag);
  endtask

  task automatic run_upd(int n, string tag);
    for (int k = 0; k < n; k++) begin
      upd = 1'b1; next_sample();
      cyc(tag);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare("R10");

    voice_on = 1'b1;
    // volume ramps up and down
    ld_val(0, 16'h1000, "R2"); ld_ramp(0, 5, 1'b1, "R4");
    ld_val(1, 16'h2000, "R2"); ld_ramp(1, 8'hFB, 1'b0, "R2");
    ld_cnt(12, "R1");
    run_upd(15, "R2");
    // saturation at both ends
    ld_val(0, 16'hFFF0, "R3"); ld_ramp(0, 8'h7F, 1'b0, "R3");
    ld_val(1, 16'h0010, "R3"); ld_ramp(1, 8'h80, 1'b0, "R3");
    ld_cnt(5, "R3");
    run_upd(6, "R3");
    // slow coefficient lanes
    ld_val(2, 16'h0100, "R4"); ld_ramp(2, 3, 1'b1, "R4");
    ld_val(3, 16'h0100, "R4"); ld_ramp(3, 8'hFE, 1'b0, "R4");
    ld_cnt(20, "R4");
    for (int k = 0; k < 10; k++) begin
      run_upd(2, "R4");
      cyc("R1");
    end
    // tick counter advances with idle envelope, shifting slow phase
    ld_cnt(0, "R5");
    ld_ramp(3, 8'h05, 1'b1, "R5");
    run_upd(3, "R5");
    ld_cnt(17, "R5");
    run_upd(18, "R5");
    // zero counter: no further change
    run_upd(4, "R1");
    // exponent sweep with extreme samples
    for (int e = 0; e < 16; e++) begin
      ld_val(0, (e << 12) | 16'h0FF0, "R6");
      ld_val(1, (e << 12) | 16'h0350, "R6");
      upd = 1'b1; sample_in = 16'h8000; cyc("R6");
      upd = 1'b1; sample_in = 16'h7FFF; cyc("R6");
      upd = 1'b1; sample_in = 16'hFFFF; cyc("R6");
    end
    // mute and inactive voice
    mute = 1'b1; run_upd(2, "R7");
    mute = 1'b0; voice_on = 1'b0; run_upd(2, "R7");
    voice_on = 1'b1;
    // load priority in a stepping tick
    ld_ramp(0, 9, 1'b0, "R8"); ld_cnt(6, "R8");
    upd = 1'b1; cnt_ld = 1'b1; cnt_din = 9'd40; val_ld[0] = 1'b1; val_din[15:0] = 16'h4321;
    next_sample(); cyc("R8");
    upd = 1'b1; ramp_ld[0] = 1'b1; ramp_din = 8'hF0; next_sample(); cyc("R8");
    run_upd(2, "R8");
    // output hold between strobes
    run_upd(1, "R9");
    for (int k = 0; k < 4; k++) begin next_sample(); cyc("R9"); end
    run_upd(1, "R9");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule